// File: doc/BRIEF.md
# Not-Recently-Used Eviction Victim Selector

This block keeps two usage bits for each of a fixed number of page frames. One bit records a recent reference. The other records a write since the frame was brought in. When asked, it names one frame to evict. A frame becomes resident on its first access. From then on, every access marks it as used, and a write access also marks it as dirty. A periodic tick ages the frames by clearing every used mark, while the dirty marks survive. An invalidate returns one frame to the empty state.

On a victim request, the resident frames are sorted into four classes by their two bits. The victim is taken from the lowest class that has at least one member. Within that class the choice is pseudo-random. A free-running LFSR supplies a rotating start point, and a circular scan from that point takes the first member of the class. The index and class of the chosen frame are registered. They appear one cycle after the request, together with a valid pulse.

Top module: `nru_victim_sel`

## Requirements
- R1: After reset no frame is resident, every used and dirty mark is clear, and `victim_vld` is low.
- R2: An access makes its frame resident and sets its used mark. A write access also sets the dirty mark. A read access leaves the dirty mark unchanged.
- R3: A frame's class is the 2-bit value {used, dirty}. The values are: 0 = neither mark, 1 = dirty only, 2 = used only, 3 = both. `victim_cls` reports the victim's class in this encoding.
- R4: The victim is a resident frame, and no resident frame lies in a lower class than the victim.
- R5: Within the lowest non-empty class, the member is chosen pseudo-randomly, not always by lowest index. Repeated requests over a class with several members name several different frames.
- R6: `victim_vld` is high in the cycle after a request if at least one frame is resident, and low otherwise. It is low in every cycle that does not follow a request.
- R7: A tick clears the used mark of every frame and leaves all dirty marks and residency unchanged.
- R8: An access in the same cycle as a tick leaves the accessed frame's used mark set.
- R9: An invalidate clears the frame's marks and its residency, so the frame is not selected until it is accessed again. An invalidate wins over an access to the same frame in the same cycle.
- R10: A request is judged on the state before any access, tick or invalidate in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_vld | input | 1 | Frame access strobe |
| acc_idx | input | IDX_W | Index of the accessed frame |
| acc_wr | input | 1 | Access is a write |
| tick | input | 1 | Aging tick, clears all used marks |
| inv_vld | input | 1 | Invalidate strobe |
| inv_idx | input | IDX_W | Index of the frame to invalidate |
| vreq | input | 1 | Victim request |
| victim_vld | output | 1 | Victim result valid, one cycle after request |
| victim_idx | output | IDX_W | Index of the chosen frame |
| victim_cls | output | 2 | Class of the chosen frame |

## Verification
The bench builds the block with eight frames and the default 16-bit LFSR. With eight frames, a sweep can load hundreds of distinct class and residency patterns, including empty and single-member classes, and check each victim against an arithmetic model. The small frame count also lets one class hold every frame, so the pseudo-random spread across members shows up within a few dozen requests. The same-cycle collisions between access, tick, invalidate and request are driven directly on chosen frames.

// File: rtl/nru_pkg.sv
package nru_pkg;
   typedef enum logic [1:0] {
      CLS_IDLE_CLEAN = 2'd0,
      CLS_IDLE_DIRTY = 2'd1,
      CLS_USED_CLEAN = 2'd2,
      CLS_USED_DIRTY = 2'd3
   } nru_cls_e;

   localparam int NUM_CLASSES = 4;

   function automatic nru_cls_e cls_of(input logic used, input logic dirty);
      return nru_cls_e'({used, dirty});
   endfunction
endpackage

// File: rtl/nru_frame_bank.sv
module nru_frame_bank #(
   parameter int FRAMES = 16,
   parameter int IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_vld,
   input  logic [IDX_W-1:0]  acc_idx,
   input  logic              acc_wr,
   input  logic              tick,
   input  logic              inv_vld,
   input  logic [IDX_W-1:0]  inv_idx,
   output logic [FRAMES-1:0] res_q,
   output logic [FRAMES-1:0] used_q,
   output logic [FRAMES-1:0] dirty_q
);
   for (genvar g = 0; g < FRAMES; g++) begin : g_frame
      logic hit_acc;
      logic hit_inv;
      assign hit_acc = acc_vld && (acc_idx == IDX_W'(g));
      assign hit_inv = inv_vld && (inv_idx == IDX_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            res_q[g]   <= 1'b0;
            used_q[g]  <= 1'b0;
            dirty_q[g] <= 1'b0;
         end else if (hit_inv) begin
            res_q[g]   <= 1'b0;
            used_q[g]  <= 1'b0;
            dirty_q[g] <= 1'b0;
         end else begin
            if (hit_acc) begin
               res_q[g]  <= 1'b1;
               used_q[g] <= 1'b1;
            end else if (tick) begin
               used_q[g] <= 1'b0;
            end
            if (hit_acc && acc_wr) begin
               dirty_q[g] <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/nru_lfsr.sv
module nru_lfsr #(
   parameter int             W    = 16,
   parameter logic [W-1:0]   TAPS = 16'hB400,
   parameter logic [W-1:0]   SEED = 16'hACE1
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] state_q
);
   if (SEED == '0) begin : g_bad_seed
      $error("nru_lfsr: SEED must be nonzero");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEED;
      end else if (state_q[0]) begin
         state_q <= (state_q >> 1) ^ TAPS;
      end else begin
         state_q <= state_q >> 1;
      end
   end
endmodule

// File: rtl/nru_circ_pick.sv
module nru_circ_pick #(
   parameter int N     = 16,
   parameter int IDX_W = 4
) (
   input  logic [N-1:0]     mask,
   input  logic [IDX_W-1:0] start,
   output logic             found,
   output logic [IDX_W-1:0] idx
);
   localparam int SUM_W = IDX_W + 1;

   logic [2*N-1:0]   dbl;
   logic [N-1:0]     rot;
   logic [IDX_W-1:0] off;
   logic [SUM_W-1:0] sum;

   assign dbl   = {mask, mask} >> start;
   assign rot   = dbl[N-1:0];
   assign found = |mask;

   always_comb begin
      off = '0;
      for (int k = N - 1; k >= 0; k--) begin
         if (rot[k]) off = IDX_W'(k);
      end
   end

   always_comb begin
      sum = SUM_W'(start) + SUM_W'(off);
      if (sum >= SUM_W'(N)) sum = sum - SUM_W'(N);
      idx = sum[IDX_W-1:0];
   end
endmodule

// File: rtl/nru_victim_sel.sv
module nru_victim_sel
   import nru_pkg::*;
#(
   parameter int                FRAMES    = 16,
   parameter int                LFSR_W    = 16,
   parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
   parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
   localparam int               IDX_W     = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_vld,
   input  logic [IDX_W-1:0] acc_idx,
   input  logic             acc_wr,
   input  logic             tick,
   input  logic             inv_vld,
   input  logic [IDX_W-1:0] inv_idx,
   input  logic             vreq,
   output logic             victim_vld,
   output logic [IDX_W-1:0] victim_idx,
   output logic [1:0]       victim_cls
);
   localparam bit IS_POW2 = (FRAMES & (FRAMES - 1)) == 0;

   if (FRAMES < 2) begin : g_bad_frames
      $error("nru_victim_sel: FRAMES must be at least 2");
   end
   if (LFSR_W < IDX_W) begin : g_bad_lfsr
      $error("nru_victim_sel: LFSR_W must cover the frame index");
   end

   logic [FRAMES-1:0] res_q, used_q, dirty_q;
   logic [LFSR_W-1:0] lfsr_q;
   logic [IDX_W-1:0]  start_idx;

   nru_frame_bank #(.FRAMES(FRAMES), .IDX_W(IDX_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .acc_vld(acc_vld), .acc_idx(acc_idx), .acc_wr(acc_wr),
      .tick(tick), .inv_vld(inv_vld), .inv_idx(inv_idx),
      .res_q(res_q), .used_q(used_q), .dirty_q(dirty_q)
   );

   nru_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
      .clk(clk), .rst_n(rst_n), .state_q(lfsr_q)
   );

   if (IS_POW2) begin : g_start_pow2
      assign start_idx = lfsr_q[IDX_W-1:0];
   end else begin : g_start_mod
      logic [LFSR_W-1:0] rem;
      assign rem       = lfsr_q % LFSR_W'(FRAMES);
      assign start_idx = rem[IDX_W-1:0];
   end

   // one membership mask per class
   logic [FRAMES-1:0] cls_mask [NUM_CLASSES];
   for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
      for (genvar f = 0; f < FRAMES; f++) begin : g_mem
         assign cls_mask[c][f] = res_q[f] && (cls_of(used_q[f], dirty_q[f]) == nru_cls_e'(c));
      end
   end

   nru_cls_e          low_cls;
   logic [FRAMES-1:0] low_mask;
   always_comb begin
      low_cls  = CLS_USED_DIRTY;
      low_mask = cls_mask[NUM_CLASSES-1];
      for (int c = NUM_CLASSES - 2; c >= 0; c--) begin
         if (|cls_mask[c]) begin
            low_cls  = nru_cls_e'(c);
            low_mask = cls_mask[c];
         end
      end
   end

   logic             pick_found;
   logic [IDX_W-1:0] pick_idx;
   nru_circ_pick #(.N(FRAMES), .IDX_W(IDX_W)) u_pick (
      .mask(low_mask), .start(start_idx), .found(pick_found), .idx(pick_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         victim_vld <= 1'b0;
         victim_idx <= '0;
         victim_cls <= '0;
      end else begin
         victim_vld <= vreq && pick_found;
         if (vreq && pick_found) begin
            victim_idx <= pick_idx;
            victim_cls <= low_cls;
         end
      end
   end
endmodule

// File: rtl/nru_victim_sel_chk.sv
module nru_victim_sel_chk #(
   parameter int FRAMES = 16,
   parameter int IDX_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_vld,
   input logic [IDX_W-1:0]  acc_idx,
   input logic              acc_wr,
   input logic              tick,
   input logic              inv_vld,
   input logic [IDX_W-1:0]  inv_idx,
   input logic              vreq,
   input logic              victim_vld,
   input logic [IDX_W-1:0]  victim_idx,
   input logic [1:0]        victim_cls,
   input logic [FRAMES-1:0] res_q,
   input logic [FRAMES-1:0] used_q,
   input logic [FRAMES-1:0] dirty_q
);
   logic [FRAMES-1:0] p_res, p_used, p_dirty;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         p_res <= '0; p_used <= '0; p_dirty <= '0;
      end else begin
         p_res <= res_q; p_used <= used_q; p_dirty <= dirty_q;
      end
   end

   logic [FRAMES-1:0] lower_prev;
   always_comb begin
      for (int f = 0; f < FRAMES; f++)
         lower_prev[f] = p_res[f] && ({p_used[f], p_dirty[f]} < victim_cls);
   end

   // R2
   a_r2_access_marks_used: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_vld && !(inv_vld && inv_idx == acc_idx)) |=>
         (((res_q & used_q) >> $past(acc_idx)) & FRAMES'(1)) != '0);
   a_r2_write_marks_dirty: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_vld && acc_wr && !(inv_vld && inv_idx == acc_idx)) |=>
         ((dirty_q >> $past(acc_idx)) & FRAMES'(1)) != '0);
   // R7
   a_r7_tick_clears_used: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !acc_vld) |=> used_q == '0);
   a_r7_tick_keeps_dirty: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !acc_vld && !inv_vld) |=> dirty_q == $past(dirty_q));
   // R9
   a_r9_inval_empties: assert property (@(posedge clk) disable iff (!rst_n)
      inv_vld |=> (((res_q | used_q | dirty_q) >> $past(inv_idx)) & FRAMES'(1)) == '0);
   // R6
   a_r6_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      vreq |=> victim_vld == (|$past(res_q)));
   a_r6_no_valid_without_req: assert property (@(posedge clk) disable iff (!rst_n)
      !vreq |=> !victim_vld);
   // R4
   a_r4_victim_resident: assert property (@(posedge clk) disable iff (!rst_n)
      victim_vld |-> ((p_res >> victim_idx) & FRAMES'(1)) != '0);
   a_r4_no_lower_class: assert property (@(posedge clk) disable iff (!rst_n)
      victim_vld |-> lower_prev == '0);
   // R3
   a_r3_class_matches: assert property (@(posedge clk) disable iff (!rst_n)
      victim_vld |-> victim_cls == {p_used[victim_idx], p_dirty[victim_idx]});
endmodule

bind nru_victim_sel nru_victim_sel_chk #(.FRAMES(FRAMES), .IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_idx(acc_idx), .acc_wr(acc_wr),
   .tick(tick), .inv_vld(inv_vld), .inv_idx(inv_idx), .vreq(vreq),
   .victim_vld(victim_vld), .victim_idx(victim_idx), .victim_cls(victim_cls),
   .res_q(res_q), .used_q(used_q), .dirty_q(dirty_q)
);

// File: tb/sim_nru_victim_sel.sv
module sim_nru_victim_sel;
   localparam int F  = 8;
   localparam int IW = 3;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n, acc_vld, acc_wr, tick, inv_vld, vreq;
   logic [IW-1:0] acc_idx, inv_idx;
   logic          victim_vld;
   logic [IW-1:0] victim_idx;
   logic [1:0]    victim_cls;

   nru_victim_sel #(.FRAMES(F)) u0 (
      .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_idx(acc_idx), .acc_wr(acc_wr),
      .tick(tick), .inv_vld(inv_vld), .inv_idx(inv_idx), .vreq(vreq),
      .victim_vld(victim_vld), .victim_idx(victim_idx), .victim_cls(victim_cls)
   );

   int checks = 0;
   int errors = 0;
   bit res_m [F];
   bit used_m [F];
   bit dirty_m [F];
   int want [F];
   bit finished = 0;

   task automatic check(input bit ok, input string req, input string detail);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: %s", req, detail);
      end
   endtask

   // one clock of stimulus; checks the registered victim result
   task automatic cyc(input bit a, input int ai, input bit aw, input bit tk,
                      input bit vr, input bit iv, input int ii, input string req);
      int minc;
      bit pr [F];
      int pc [F];
      acc_vld = a; acc_idx = IW'(ai); acc_wr = aw; tick = tk;
      vreq = vr; inv_vld = iv; inv_idx = IW'(ii);
      minc = 4;
      for (int f = 0; f < F; f++) begin
         pr[f] = res_m[f];
         pc[f] = used_m[f] * 2 + dirty_m[f];
         if (pr[f] && pc[f] < minc) minc = pc[f];
      end
      @(negedge clk);
      for (int f = 0; f < F; f++) begin
         if (iv && ii == f) begin
            res_m[f] = 0; used_m[f] = 0; dirty_m[f] = 0;
         end else begin
            if (a && ai == f) begin res_m[f] = 1; used_m[f] = 1; end
            else if (tk) used_m[f] = 0;
            if (a && ai == f && aw) dirty_m[f] = 1;
         end
      end
      if (vr && minc == 4) begin
         check(victim_vld == 1'b0, {req, "/R6"},
               $sformatf("valid actual %0b expected 0 (nothing resident)", victim_vld));
      end else if (vr) begin
         check(victim_vld == 1'b1, {req, "/R6"},
               $sformatf("valid actual %0b expected 1", victim_vld));
         check(int'(victim_cls) == minc, {req, "/R4"},
               $sformatf("class actual %0d expected %0d", victim_cls, minc));
         check(pr[victim_idx] && pc[victim_idx] == minc, {req, "/R3"},
               $sformatf("frame %0d resident %0b class %0d expected class %0d",
                         victim_idx, pr[victim_idx], pc[victim_idx], minc));
      end else begin
         check(victim_vld == 1'b0, "R6",
               $sformatf("valid without request actual %0b expected 0", victim_vld));
      end
      acc_vld = 0; acc_wr = 0; tick = 0; vreq = 0; inv_vld = 0;
   endtask

   task automatic clear_all();
      for (int f = 0; f < F; f++) cyc(0, 0, 0, 0, 0, 1, f, "R9");
   endtask

   // load class pattern want[]: 0..3 = class, 4 = not resident
   task automatic load_pattern();
      clear_all();
      for (int f = 0; f < F; f++)
         if (want[f] != 4) cyc(1, f, want[f] % 2 == 1, 0, 0, 0, 0, "R2");
      cyc(0, 0, 0, 1, 0, 0, 0, "R7");
      for (int f = 0; f < F; f++)
         if (want[f] == 2 || want[f] == 3) cyc(1, f, 0, 0, 0, 0, 0, "R2");
   endtask

   initial begin
      rst_n = 0; acc_vld = 0; acc_wr = 0; tick = 0; vreq = 0; inv_vld = 0;
      acc_idx = '0; inv_idx = '0;
      for (int f = 0; f < F; f++) begin res_m[f] = 0; used_m[f] = 0; dirty_m[f] = 0; end
      repeat (3) @(negedge clk);
      // R1: reset state
      check(victim_vld == 1'b0, "R1", $sformatf("valid after reset actual %0b expected 0", victim_vld));
      rst_n = 1;
      cyc(0, 0, 0, 0, 1, 0, 0, "R1");

      // R2 / R3: single frame read then write
      cyc(1, 5, 0, 0, 0, 0, 0, "R2");
      cyc(0, 0, 0, 0, 1, 0, 0, "R2");
      check(victim_idx == 3'd5 && victim_cls == 2'd2, "R2",
            $sformatf("read frame: idx %0d cls %0d expected 5 2", victim_idx, victim_cls));
      cyc(1, 5, 1, 0, 0, 0, 0, "R2");
      cyc(0, 0, 0, 0, 1, 0, 0, "R2");
      check(victim_cls == 2'd3, "R3", $sformatf("written frame cls %0d expected 3", victim_cls));
      // R7: tick ages to dirty-only
      cyc(0, 0, 0, 1, 0, 0, 0, "R7");
      cyc(0, 0, 0, 0, 1, 0, 0, "R7");
      check(victim_cls == 2'd1, "R7", $sformatf("after tick cls %0d expected 1", victim_cls));

      // R8: access and tick together
      clear_all();
      cyc(1, 3, 0, 1, 0, 0, 0, "R8");
      cyc(0, 0, 0, 0, 1, 0, 0, "R8");
      check(victim_vld && victim_idx == 3'd3 && victim_cls == 2'd2, "R8",
            $sformatf("idx %0d cls %0d expected 3 2", victim_idx, victim_cls));

      // R9: invalidate beats access on the same frame
      clear_all();
      cyc(1, 2, 1, 0, 0, 1, 2, "R9");
      cyc(0, 0, 0, 0, 1, 0, 0, "R9");
      check(victim_vld == 1'b0, "R9", $sformatf("valid %0b expected 0 after invalidate", victim_vld));
      // R9: invalidated frame skipped while a higher class exists
      cyc(1, 4, 1, 0, 0, 0, 0, "R9");
      cyc(1, 6, 0, 0, 0, 0, 0, "R9");
      cyc(0, 0, 0, 0, 0, 1, 6, "R9");
      cyc(0, 0, 0, 0, 1, 0, 0, "R9");
      check(victim_idx == 3'd4 && victim_cls == 2'd3, "R9",
            $sformatf("idx %0d cls %0d expected 4 3", victim_idx, victim_cls));

      // R10: request sees state before a same-cycle write
      clear_all();
      cyc(1, 1, 0, 0, 0, 0, 0, "R10");
      cyc(0, 0, 0, 1, 0, 0, 0, "R10");
      cyc(1, 1, 1, 0, 1, 0, 0, "R10");
      check(victim_cls == 2'd0, "R10", $sformatf("cls %0d expected 0 (pre-write state)", victim_cls));

      // R4 sweep over class patterns
      for (int t = 0; t < 300; t++) begin
         for (int f = 0; f < F; f++) want[f] = (t + f * 5 + (t / 3) * f + (t / 17) * f * f) % 5;
         load_pattern();
         cyc(0, 0, 0, 0, 1, 0, 0, "R4");
         cyc(0, 0, 0, 0, 1, 0, 0, "R4");
      end

      // R5: spread inside one class holding every frame
      begin
         bit seen [F];
         int distinct = 0;
         bit not_lowest = 0;
         for (int f = 0; f < F; f++) begin want[f] = 1; seen[f] = 0; end
         load_pattern();
         for (int n = 0; n < 64; n++) begin
            cyc(0, 0, 0, 0, 1, 0, 0, "R5");
            seen[victim_idx] = 1;
            if (victim_idx != 0) not_lowest = 1;
         end
         for (int f = 0; f < F; f++) distinct += seen[f];
         check(distinct >= 4, "R5", $sformatf("distinct victims %0d expected >= 4", distinct));
         check(not_lowest, "R5", "victims actual always index 0 expected spread");
      end

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule